// File: doc/BRIEF.md
# Ripple-chain leading zero counter

This block is purely combinational. It counts the run of zeros at the top of a `WIDTH`-bit data word, which is 8 bits by default. Below the least significant data bit it adds a constant one, the guard bit. A chain of `WIDTH+1` identical two-input, two-output cells then walks from the most significant position toward the guard bit. Each cell passes a "found" flag to the next cell down. Only the first set bit the chain meets raises its select line, so the select vector is one-hot. A binary encoder turns the position of that select line into the count.

The guard bit makes sure an all-zero word still selects a position, which is position `WIDTH`. For this reason the count is one bit wider than `log2(WIDTH)`. A two-bit mode input changes how the word is prepared before the chain. One mode reverses the bit order, so the block counts trailing zeros. Another mode inverts the bits, so the block counts leading ones. The chain and the encoder are the same in every mode.

Top module: `ripple_lzc`

## Requirements
- R1: The count output `cnt_o` is `$clog2(WIDTH)+1` bits wide, which is 4 bits at the default `WIDTH` of 8.
- R2: With `mode_i` = 2'b00, `cnt_o` equals the number of consecutive zero bits starting at bit `WIDTH-1` and moving down to the first one.
- R3: For every data word and mode, `cnt_o` lies in the range 0 to `WIDTH`. Exactly one chain position is selected, and the guard position is reached whenever no data bit qualifies.
- R4: With `mode_i` = 2'b00 and an all-zero word, `cnt_o` equals `WIDTH` (8).
- R5: With `mode_i` = 2'b00, word 8'b00111010 gives 2, and word 8'b10101000 gives 0.
- R6: With `mode_i` = 2'b01, `cnt_o` equals the number of consecutive zero bits starting at bit 0 and moving up. An all-zero word gives `WIDTH`.
- R7: With `mode_i` = 2'b10, `cnt_o` equals the number of consecutive one bits starting at bit `WIDTH-1` and moving down. An all-ones word gives `WIDTH`.
- R8: With `mode_i` = 2'b11, the result is identical to the result for 2'b00 on the same word.
- R9: The block holds no state. `cnt_o` reflects the present `data_i` and `mode_i` with no clock, and settles again after each input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Data word to be scanned |
| mode_i | input | 2 | 00 leading zeros, 01 trailing zeros, 10 leading ones, 11 same as 00 |
| cnt_o | output | $clog2(WIDTH)+1 | Count of the selected run |

## Verification
A broken found flag at any chain cell would let two select lines rise together or none at all. The encoder would then OR two positions together or output zero, and `cnt_o` would show a wrong count on the same evaluation, for every word whose first qualifying bit lies at or below the broken cell. A wrong mode preparation, such as a missing reversal or inversion, would show up on almost any word that is not symmetric. Checking every word in every mode, plus random and directed words, exposes each cell position and each mode path at the port.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
  typedef enum logic [1:0] {
    MODE_LZ  = 2'b00,
    MODE_TZ  = 2'b01,
    MODE_LO  = 2'b10,
    MODE_RSV = 2'b11
  } lzc_mode_e;
endpackage

// File: rtl/lzc_cell.sv
module lzc_cell (
  input  logic d_i,
  input  logic f_i,
  output logic hit_o,
  output logic f_o
);
  assign hit_o = d_i & ~f_i;
  assign f_o   = f_i | d_i;
endmodule

// File: rtl/lzc_front.sv
module lzc_front
  import lzc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH:0]   seq_o   // seq_o[k]: scan position k, k=0 first
);
  lzc_mode_e mode;
  assign mode = lzc_mode_e'(mode_i);

  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      unique case (mode)
        MODE_TZ: seq_o[k] = data_i[k];
        MODE_LO: seq_o[k] = ~data_i[WIDTH-1-k];
        default: seq_o[k] = data_i[WIDTH-1-k];
      endcase
    end
    seq_o[WIDTH] = 1'b1;  // guard bit
  end
endmodule

// File: rtl/lzc_chain.sv
module lzc_chain #(
  parameter int WIDTH = 8,
  localparam int LEN = WIDTH + 1
) (
  input  logic [LEN-1:0] seq_i,
  output logic [LEN-1:0] hit_o,
  output logic           found_o
);
  logic [LEN:0] found;
  assign found[0] = 1'b0;

  for (genvar k = 0; k < LEN; k++) begin : g_cell
    lzc_cell u_cell (
      .d_i  (seq_i[k]),
      .f_i  (found[k]),
      .hit_o(hit_o[k]),
      .f_o  (found[k+1])
    );
  end

  assign found_o = found[LEN];
endmodule

// File: rtl/lzc_onehot_enc.sv
module lzc_onehot_enc #(
  parameter int WIDTH = 8,
  localparam int LEN = WIDTH + 1,
  localparam int CNT_W = $clog2(WIDTH) + 1
) (
  input  logic [LEN-1:0]   hit_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < LEN; k++) begin
      if (hit_i[k]) cnt_o = cnt_o | CNT_W'(k);
    end
  end

  always_comb begin
    AST_HIT_ONEHOT: assert ($onehot(hit_i));  // R3
    AST_CNT_RANGE: assert (int'(cnt_o) <= WIDTH);  // R3
  end
endmodule

// File: rtl/ripple_lzc.sv
module ripple_lzc
  import lzc_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int LEN = WIDTH + 1,
  localparam int CNT_W = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [1:0]       mode_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [LEN-1:0] seq;
  logic [LEN-1:0] hit;
  logic           found;

  lzc_front #(.WIDTH(WIDTH)) u_front (
    .data_i(data_i),
    .mode_i(mode_i),
    .seq_o (seq)
  );

  lzc_chain #(.WIDTH(WIDTH)) u_chain (
    .seq_i  (seq),
    .hit_o  (hit),
    .found_o(found)
  );

  lzc_onehot_enc #(.WIDTH(WIDTH)) u_enc (
    .hit_i(hit),
    .cnt_o(cnt_o)
  );

  // port-level relations between data, mode and count
  always_comb begin
    AST_GUARD_REACHED: assert (found);  // R3
    if (data_i == '0 && (mode_i == 2'b00 || mode_i == 2'b11))
      AST_ALL_ZERO: assert (int'(cnt_o) == WIDTH);  // R4
    for (int k = 0; k < WIDTH; k++) begin
      if (mode_i == 2'b00 || mode_i == 2'b11) begin
        if (k < int'(cnt_o)) AST_LZ_ZERO_ABOVE: assert (!data_i[WIDTH-1-k]);  // R2
        if (k == int'(cnt_o)) AST_LZ_ONE_AT: assert (data_i[WIDTH-1-k]);  // R2
      end
      if (mode_i == 2'b01) begin
        if (k < int'(cnt_o)) AST_TZ_ZERO_BELOW: assert (!data_i[k]);  // R6
        if (k == int'(cnt_o)) AST_TZ_ONE_AT: assert (data_i[k]);  // R6
      end
      if (mode_i == 2'b10) begin
        if (k < int'(cnt_o)) AST_LO_ONE_ABOVE: assert (data_i[WIDTH-1-k]);  // R7
        if (k == int'(cnt_o)) AST_LO_ZERO_AT: assert (!data_i[WIDTH-1-k]);  // R7
      end
    end
  end
endmodule

// File: tb/sim_ripple_lzc.sv
module sim_ripple_lzc;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int CW = $clog2(W) + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] data;
  logic [1:0] mode;
  logic [CW-1:0] cnt;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ripple_lzc #(.WIDTH(W)) u0 (
    .data_i(data),
    .mode_i(mode),
    .cnt_o (cnt)
  );

  function automatic int ref_cnt(logic [W-1:0] d, logic [1:0] m);
    int n = 0;
    if (m == 2'b01) begin
      for (int k = 0; k < W; k++) begin
        if (d[k]) break;
        n++;
      end
    end else begin
      logic [W-1:0] v = (m == 2'b10) ? ~d : d;
      for (int k = W - 1; k >= 0; k--) begin
        if (v[k]) break;
        n++;
      end
    end
    return n;
  endfunction

  function automatic string tag_of(logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s data=%b mode=%b actual=%0d expected=%0d", req, data, mode, act, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] d, logic [1:0] m, string req);
    @(negedge clk);
    data = d;
    mode = m;
    #1;
    check(req, int'(cnt), ref_cnt(d, m));
    check("R3", int'(int'(cnt) <= W), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    data = '0;
    mode = 2'b00;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R4 reset", int'(cnt), W);
    check("R1", $bits(cnt), 4);

    // directed corners
    @(negedge clk); data = 8'b0000_0000; mode = 2'b00; #1; check("R4", int'(cnt), 8);
    @(negedge clk); data = 8'b0011_1010; mode = 2'b00; #1; check("R5", int'(cnt), 2);
    @(negedge clk); data = 8'b1010_1000; mode = 2'b00; #1; check("R5", int'(cnt), 0);
    @(negedge clk); data = 8'b0000_0001; mode = 2'b00; #1; check("R2", int'(cnt), 7);
    @(negedge clk); data = 8'b0000_0000; mode = 2'b01; #1; check("R6", int'(cnt), 8);
    @(negedge clk); data = 8'b1000_0000; mode = 2'b01; #1; check("R6", int'(cnt), 7);
    @(negedge clk); data = 8'b1111_1111; mode = 2'b10; #1; check("R7", int'(cnt), 8);
    @(negedge clk); data = 8'b1110_1111; mode = 2'b10; #1; check("R7", int'(cnt), 3);
    @(negedge clk); data = 8'b0011_1010; mode = 2'b11; #1; check("R8", int'(cnt), 2);
    @(negedge clk); data = 8'b0000_0000; mode = 2'b11; #1; check("R8", int'(cnt), 8);

    // R9: several changes inside one clock period, no edge in between
    @(posedge clk); #1;
    data = 8'b0001_0000; mode = 2'b00; #1; check("R9", int'(cnt), 3);
    data = 8'b0001_0000; mode = 2'b01; #1; check("R9", int'(cnt), 4);
    data = 8'b0000_0100; mode = 2'b00; #1; check("R9", int'(cnt), 5);

    // exhaustive sweep over all words and modes
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < (1 << W); d++) begin
        apply(W'(d), 2'(m), tag_of(2'(m)));
      end
    end

    // random words and modes
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] rd = W'($urandom);
      logic [1:0] rm = 2'($urandom);
      apply(rd, rm, tag_of(rm));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule